// File: doc/BRIEF.md
# Power Mode and Wake-up Controller

This block keeps track of the operating mode of a small 8-bit controller: sleep, green (low-speed sub-clock) or normal (fast main clock from the PLL). Two control bits and a strobe from the sleep instruction drive the mode. A "run-fast" bit picks normal mode. An auxiliary bit must also be clear, together with the run-fast bit, for a sleep instruction to take effect.

Each event source is mapped to one of three outcomes, and the outcome depends on the current mode: nothing, a request to vector to address 8, or a request to reset and restart at address 0. The sources are three overflow events (a timer and two counters), a watchdog timeout, a port pin change and a synchronized edge-detect pin. The requests are registered single-cycle pulses for the CPU core. The mode output, a main-clock select and the effective multiplier code are also provided for the clock tree.

Top module: `pmw_ctrl`

## Requirements
- R1: While reset is held and on the cycle after it, mode_o is 1 (green; encoding 0 = sleep, 1 = green, 2 = normal), clk_main_o is 0, and vec8_o and rst0_o are 0.
- R2: In a running mode, sleep_i with run_fast_i = 0 and aux_i = 0 gives mode_o = 0 from the next cycle. A sleep strobe with either bit at 1 does not enter sleep.
- R3: In a running mode without a qualifying sleep strobe, mode_o is 2 with clk_main_o = 1 on the cycle after run_fast_i = 1, and mode_o is 1 with clk_main_o = 0 on the cycle after run_fast_i = 0, whatever aux_i is.
- R4: mul_o equals mul_i while mode_o is 2, and is 0 otherwise.
- R5: An overflow event on bit i of ovf_evt_i gives a one-cycle vec8_o pulse on the next cycle only when the mode is running, ovf_en_i[i] = 1 and gie_i = 1. In sleep it has no effect.
- R6: wdt_to_i gives a one-cycle rst0_o pulse on the next cycle in every mode.
- R7: A change on port_chg_i bit j with port_en_i[j] = 1 gives rst0_o on the next cycle when asleep. In a running mode it gives vec8_o when gie_i = 1. Changes on bits whose enable is 0 have no effect.
- R8: edi_pin_i goes through two synchronizing flops before edge detection. The rising edge is used when edi_rise_i = 1 and the falling edge otherwise. A selected edge applied before clock edge k gives vec8_o after clock edge k+2, only in a running mode and with edi_en_i = 1 and gie_i = 1. In sleep the edge is ignored.
- R9: rst0_o and vec8_o are never high together. A reset outcome in the same cycle as an interrupt outcome suppresses the interrupt.
- R10: A reset outcome while asleep makes the block leave sleep on the next cycle, into the mode selected by run_fast_i.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| run_fast_i | input | 1 | Mode bit selecting normal (1) or green (0) |
| aux_i | input | 1 | Auxiliary mode bit, must be 0 for sleep entry |
| sleep_i | input | 1 | Sleep instruction strobe |
| mul_i | input | 2 | Main clock multiplier code |
| gie_i | input | 1 | Global interrupt enable |
| ovf_evt_i | input | 3 | Timer / counter 1 / counter 2 overflow pulses |
| ovf_en_i | input | 3 | Per-overflow interrupt enables |
| wdt_to_i | input | 1 | Watchdog timeout pulse |
| port_chg_i | input | 8 | Per-pin port change pulses |
| port_en_i | input | 8 | Per-pin change enables |
| edi_pin_i | input | 1 | Asynchronous edge-detect pin |
| edi_en_i | input | 1 | Edge-detect interrupt enable |
| edi_rise_i | input | 1 | Edge select: 1 rising, 0 falling |
| mode_o | output | 2 | Current mode (0 sleep, 1 green, 2 normal) |
| clk_main_o | output | 1 | 1 selects the PLL main clock, 0 the sub-clock |
| mul_o | output | 2 | Effective multiplier code |
| vec8_o | output | 1 | Interrupt request, vector to address 8 |
| rst0_o | output | 1 | Reset request, restart at address 0 |

## Verification
The properties assume that the event inputs are single-cycle pulses in step with the clock. They also assume that the control bits only change between cycles, so that an outcome follows from the mode and inputs of one cycle. The bench sets every input at a falling edge and holds the events for exactly one cycle. It always returns to a known mode before the next vector, using a watchdog pulse to leave sleep. The edge-detect pin is the only input treated as asynchronous. The bench moves it only after the previous edge has fully drained, with its enable cleared during the preparing toggle.

// File: rtl/pmw_pkg.sv
package pmw_pkg;

    typedef enum logic [1:0] {
        MODE_SLEEP  = 2'd0,
        MODE_GREEN  = 2'd1,
        MODE_NORMAL = 2'd2
    } pmw_mode_e;

    typedef struct packed {
        logic vec8;
        logic rst0;
    } pmw_req_t;

    // mode taken when running (or when waking) for a given run-fast bit
    function automatic pmw_mode_e run_mode(input logic fast);
        return fast ? MODE_NORMAL : MODE_GREEN;
    endfunction

endpackage

// File: rtl/pmw_edge_sync.sv
module pmw_edge_sync (
    input  logic clk,
    input  logic rst,
    input  logic pin_i,
    input  logic rise_i,
    output logic edge_o
);
    logic s1_q, s2_q, prev_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            s1_q   <= 1'b0;
            s2_q   <= 1'b0;
            prev_q <= 1'b0;
        end else begin
            s1_q   <= pin_i;
            s2_q   <= s1_q;
            prev_q <= s2_q;
        end
    end

    always_comb begin
        if (rise_i) edge_o = s2_q & ~prev_q;
        else        edge_o = ~s2_q & prev_q;
    end
endmodule

// File: rtl/pmw_mode_fsm.sv
module pmw_mode_fsm
    import pmw_pkg::*;
(
    input  logic      clk,
    input  logic      rst,
    input  logic      fast_i,
    input  logic      aux_i,
    input  logic      sleep_i,
    input  logic      wake_i,
    output pmw_mode_e mode_o
);
    pmw_mode_e mode_q, mode_d;

    always_comb begin
        mode_d = mode_q;
        if (mode_q == MODE_SLEEP) begin
            if (wake_i) mode_d = run_mode(fast_i);
        end else if (sleep_i && !fast_i && !aux_i) begin
            mode_d = MODE_SLEEP;
        end else begin
            mode_d = run_mode(fast_i);
        end
    end

    always_ff @(posedge clk) begin
        if (rst) mode_q <= MODE_GREEN;
        else     mode_q <= mode_d;
    end

    assign mode_o = mode_q;
endmodule

// File: rtl/pmw_event_map.sv
module pmw_event_map
    import pmw_pkg::*;
#(
    parameter int NOVF  = 3,
    parameter int NPORT = 8
) (
    input  pmw_mode_e        mode_i,
    input  logic             gie_i,
    input  logic [NOVF-1:0]  ovf_evt_i,
    input  logic [NOVF-1:0]  ovf_en_i,
    input  logic             wdt_i,
    input  logic [NPORT-1:0] chg_i,
    input  logic [NPORT-1:0] chg_en_i,
    input  logic             edge_i,
    input  logic             edge_en_i,
    output pmw_req_t         req_o
);
    logic [NOVF-1:0] ovf_hit;
    logic            asleep, port_hit, irq_src, rst_src;

    for (genvar i = 0; i < NOVF; i++) begin : g_ovf
        assign ovf_hit[i] = ovf_evt_i[i] & ovf_en_i[i];
    end

    always_comb begin
        asleep   = (mode_i == MODE_SLEEP);
        port_hit = |(chg_i & chg_en_i);
        rst_src  = wdt_i | (asleep & port_hit);
        irq_src  = ~asleep & gie_i &
                   ((|ovf_hit) | port_hit | (edge_i & edge_en_i));
        req_o.rst0 = rst_src;
        req_o.vec8 = irq_src & ~rst_src;
    end
endmodule

// File: rtl/pmw_ctrl.sv
module pmw_ctrl
    import pmw_pkg::*;
#(
    parameter int NOVF  = 3,
    parameter int NPORT = 8,
    parameter int MULW  = 2
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             run_fast_i,
    input  logic             aux_i,
    input  logic             sleep_i,
    input  logic [MULW-1:0]  mul_i,
    input  logic             gie_i,
    input  logic [NOVF-1:0]  ovf_evt_i,
    input  logic [NOVF-1:0]  ovf_en_i,
    input  logic             wdt_to_i,
    input  logic [NPORT-1:0] port_chg_i,
    input  logic [NPORT-1:0] port_en_i,
    input  logic             edi_pin_i,
    input  logic             edi_en_i,
    input  logic             edi_rise_i,
    output logic [1:0]       mode_o,
    output logic             clk_main_o,
    output logic [MULW-1:0]  mul_o,
    output logic             vec8_o,
    output logic             rst0_o
);
    pmw_mode_e mode;
    pmw_req_t  req, req_q;
    logic      edi_edge;

    pmw_edge_sync u_edge (
        .clk    (clk),
        .rst    (rst),
        .pin_i  (edi_pin_i),
        .rise_i (edi_rise_i),
        .edge_o (edi_edge)
    );

    pmw_event_map #(.NOVF(NOVF), .NPORT(NPORT)) u_map (
        .mode_i    (mode),
        .gie_i     (gie_i),
        .ovf_evt_i (ovf_evt_i),
        .ovf_en_i  (ovf_en_i),
        .wdt_i     (wdt_to_i),
        .chg_i     (port_chg_i),
        .chg_en_i  (port_en_i),
        .edge_i    (edi_edge),
        .edge_en_i (edi_en_i),
        .req_o     (req)
    );

    pmw_mode_fsm u_fsm (
        .clk     (clk),
        .rst     (rst),
        .fast_i  (run_fast_i),
        .aux_i   (aux_i),
        .sleep_i (sleep_i),
        .wake_i  (req.rst0),
        .mode_o  (mode)
    );

    always_ff @(posedge clk) begin
        if (rst) req_q <= '0;
        else     req_q <= req;
    end

    assign mode_o     = mode;
    assign clk_main_o = (mode == MODE_NORMAL);
    assign mul_o      = (mode == MODE_NORMAL) ? mul_i : '0;
    assign vec8_o     = req_q.vec8;
    assign rst0_o     = req_q.rst0;
endmodule

// File: rtl/pmw_chk.sv
module pmw_chk #(
    parameter int NOVF  = 3,
    parameter int NPORT = 8,
    parameter int MULW  = 2
) (
    input logic             clk,
    input logic             rst,
    input logic             run_fast_i,
    input logic             aux_i,
    input logic             sleep_i,
    input logic [MULW-1:0]  mul_i,
    input logic             gie_i,
    input logic [NOVF-1:0]  ovf_evt_i,
    input logic [NOVF-1:0]  ovf_en_i,
    input logic             wdt_to_i,
    input logic [NPORT-1:0] port_chg_i,
    input logic [NPORT-1:0] port_en_i,
    input logic             edi_pin_i,
    input logic             edi_en_i,
    input logic             edi_rise_i,
    input logic [1:0]       mode_o,
    input logic             clk_main_o,
    input logic [MULW-1:0]  mul_o,
    input logic             vec8_o,
    input logic             rst0_o
);
    p_excl_r9: assert property (@(posedge clk) disable iff (rst)
        !(vec8_o && rst0_o));

    p_wdt_r6: assert property (@(posedge clk) disable iff (rst)
        wdt_to_i |=> rst0_o);

    p_sleep_entry_r2: assert property (@(posedge clk) disable iff (rst)
        (mode_o != 2'd0 && sleep_i && !run_fast_i && !aux_i) |=> (mode_o == 2'd0));

    p_normal_r3: assert property (@(posedge clk) disable iff (rst)
        (mode_o != 2'd0 && run_fast_i) |=> (mode_o == 2'd2 && clk_main_o));

    p_mul_r4: assert property (@(posedge clk) disable iff (rst)
        (mode_o != 2'd2) |-> (mul_o == '0));

    p_ovf_r5: assert property (@(posedge clk) disable iff (rst)
        (mode_o != 2'd0 && gie_i && |(ovf_evt_i & ovf_en_i) && !wdt_to_i) |=> vec8_o);

    p_sleep_quiet_r5: assert property (@(posedge clk) disable iff (rst)
        (mode_o == 2'd0 && !wdt_to_i && !(|(port_chg_i & port_en_i)))
        |=> (!vec8_o && !rst0_o && mode_o == 2'd0));

    p_wake_r10: assert property (@(posedge clk) disable iff (rst)
        (mode_o == 2'd0 && |(port_chg_i & port_en_i)) |=> (rst0_o && mode_o != 2'd0));
endmodule

bind pmw_ctrl pmw_chk #(.NOVF(NOVF), .NPORT(NPORT), .MULW(MULW)) u_chk (.*);

// File: tb/pmw_ctrl_tb.sv
module pmw_ctrl_tb;
    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       run_fast = 1'b0, aux = 1'b0, slp = 1'b0;
    logic [1:0] mul = 2'd0;
    logic       gie = 1'b0;
    logic [2:0] ovf = '0, ovf_en = '0;
    logic       wdt = 1'b0;
    logic [7:0] chg = '0, chg_en = '0;
    logic       pin = 1'b0, edi_en = 1'b0, edi_rise = 1'b0;
    logic [1:0] mode;
    logic       clk_main, vec8, rst0;
    logic [1:0] mul_out;
    int nvec = 0, nfail = 0;
    bit finished = 0;

    always #5 clk = ~clk;

    pmw_ctrl u_dut (
        .clk(clk), .rst(rst), .run_fast_i(run_fast), .aux_i(aux), .sleep_i(slp),
        .mul_i(mul), .gie_i(gie), .ovf_evt_i(ovf), .ovf_en_i(ovf_en),
        .wdt_to_i(wdt), .port_chg_i(chg), .port_en_i(chg_en),
        .edi_pin_i(pin), .edi_en_i(edi_en), .edi_rise_i(edi_rise),
        .mode_o(mode), .clk_main_o(clk_main), .mul_o(mul_out),
        .vec8_o(vec8), .rst0_o(rst0)
    );

    task automatic chk(input string req, input int act, input int exp);
        nvec++;
        if (act != exp) begin
            nfail++;
            $display("FAIL %s: actual %0d expected %0d at %0t", req, act, exp, $time);
        end
    endtask

    // reach running/sleep mode m (0 sleep, 1 green, 2 normal) with no pending pulses
    task automatic go_mode(input int m);
        if (mode == 2'd0 && m != 0) begin
            wdt = 1'b1;
            @(negedge clk);
            wdt = 1'b0;
        end
        run_fast = (m == 2);
        aux = 1'b0;
        slp = (m == 0);
        @(negedge clk);
        slp = 1'b0;
        @(negedge clk);
        chk(m == 0 ? "R2 sleep entry" : "R3 running mode", mode, m);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        chk("R1 mode in reset", mode, 1);
        chk("R1 vec8 in reset", vec8, 0);
        chk("R1 rst0 in reset", rst0, 0);
        rst = 1'b0;
        @(negedge clk);
        chk("R1 mode after reset", mode, 1);
        chk("R1 clk_main after reset", clk_main, 0);
        chk("R1 rst0 after reset", rst0, 0);

        // R2 / R3: aux bit and sleep strobe corner cases
        go_mode(1);
        aux = 1'b1; slp = 1'b1;
        @(negedge clk);
        slp = 1'b0;
        chk("R2 sleep blocked by aux", mode, 1);
        run_fast = 1'b1; slp = 1'b1; aux = 1'b0;
        @(negedge clk);
        slp = 1'b0;
        chk("R2 sleep blocked by run_fast", mode, 2);
        chk("R3 clk_main in normal", clk_main, 1);
        run_fast = 1'b0; aux = 1'b1;
        @(negedge clk);
        chk("R3 aux is don't-care", mode, 1);
        chk("R3 clk_main in green", clk_main, 0);
        aux = 1'b0;

        // R4 multiplier pass-through
        go_mode(2);
        for (int v = 0; v < 4; v++) begin
            mul = 2'(v);
            @(negedge clk);
            chk("R4 mul in normal", mul_out, v);
        end
        go_mode(1);
        chk("R4 mul in green", mul_out, 0);
        go_mode(0);
        chk("R4 mul in sleep", mul_out, 0);
        mul = 2'd0;

        // R5 R6 R7 R9 R10 sweep over modes and event mixes
        for (int m = 0; m < 3; m++)
            for (int g = 0; g < 2; g++)
                for (int p = 0; p < 2; p++)
                    for (int c = 0; c < 256; c++) begin
                        logic [7:0] cc;
                        logic [7:0] pe;
                        logic asleep, port_hit, e_rst, e_vec;
                        int e_mode;
                        go_mode(m);
                        cc = 8'(c);
                        pe = p ? 8'hEF : 8'h10;
                        gie = g[0]; chg_en = pe;
                        ovf = cc[2:0]; ovf_en = cc[5:3]; wdt = cc[6];
                        chg = cc[7] ? 8'h10 : 8'h00;
                        asleep   = (m == 0);
                        port_hit = |(chg & pe);
                        e_rst = cc[6] | (asleep & port_hit);
                        e_vec = !e_rst && !asleep && g[0] && ((|(cc[2:0] & cc[5:3])) || port_hit);
                        e_mode = asleep ? (e_rst ? 1 : 0) : m;
                        @(negedge clk);
                        ovf = '0; wdt = 1'b0; chg = '0;
                        chk("R6 R7 R9 rst0 outcome", rst0, e_rst);
                        chk("R5 R7 R9 vec8 outcome", vec8, e_vec);
                        chk("R10 mode after event", mode, e_mode);
                        @(negedge clk);
                        chk("R5 single-cycle pulse", vec8, 0);
                    end
        gie = 1'b0; ovf_en = '0; chg_en = '0;

        // R8 edge-detect path
        for (int m = 0; m < 3; m++)
            for (int g = 0; g < 2; g++)
                for (int en = 0; en < 2; en++)
                    for (int r = 0; r < 2; r++)
                        for (int t = 0; t < 2; t++) begin
                            logic e_vec;
                            go_mode(m);
                            gie = g[0]; edi_en = 1'b0;
                            pin = ~t[0];
                            repeat (4) @(negedge clk);
                            edi_en = en[0]; edi_rise = r[0];
                            pin = t[0];
                            e_vec = (m != 0) && g[0] && en[0] && (r[0] == t[0]);
                            @(negedge clk);
                            chk("R8 no vec after 1 edge", vec8, 0);
                            @(negedge clk);
                            chk("R8 no vec after 2 edges", vec8, 0);
                            @(negedge clk);
                            chk("R8 vec after 3 edges", vec8, e_vec);
                            chk("R8 mode unchanged", mode, m);
                            @(negedge clk);
                            chk("R8 vec pulse ends", vec8, 0);
                        end

        if (!finished) begin
            finished = 1;
            $display("== %0d vectors applied, %0d miscompares ==", nvec, nfail);
            $finish;
        end
    end

    initial begin
        repeat (190000) @(posedge clk);
        if (!finished) begin
            finished = 1;
            nfail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("== %0d vectors applied, %0d miscompares ==", nvec, nfail);
            $finish;
        end
    end
endmodule